// File: doc/BRIEF.md
# Super I/O Indexed Configuration Registers

This block holds a 256-entry byte-wide configuration space behind two adjacent byte ports on an I/O bus. Software first writes the wanted entry number to the index port, then reads or writes that entry through the data port. Only sixteen indices in the upper range accept data. Every other index ignores writes and reads back as zero. Six of the writable entries come out of reset with non-zero defaults.

The pair of ports answers only while an enable input is high. A bridge configuration bit drives that input. While it is low, the block claims no access, returns all ones and changes no state. Two of the writable entries, 0xE7 and 0xE8, select the bases of the first and second serial ports. They keep whatever value is written to them, but nothing is relocated as a result.

Top module: `sioc_cfg_regs`

## Requirements
- R1: After reset the pointer is 0x00. Entries 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other entry is 0x00.
- R2: A write strobe at address 0x03F0 (the index port) stores the write byte as the pointer at that clock edge.
- R3: A read strobe at 0x03F1 (the data port) or at 0x03F0 returns, in the same cycle, the entry selected by the pointer.
- R4: A write strobe at the data port, with the pointer at 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC, replaces that entry at the clock edge. A read on the next cycle returns the new value.
- R5: A data-port write with the pointer at any other index leaves the entry unchanged.
- R6: Entries 0xE7 and 0xE8 accept any byte, including values other than their defaults.
- R7: While cfg_en_i is low, io_hit_o is 0 and io_rdata_o is 0xFF. Writes to either port change neither the pointer nor any entry.
- R8: An access at any address other than 0x03F0 or 0x03F1 is not claimed (io_hit_o 0, io_rdata_o 0xFF) and changes nothing.
- R9: A data-port read and write strobed in the same cycle return the entry's old value. The write takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Window enable from bridge configuration bit |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write byte |
| io_rdata_o | output | 8 | Read byte (0xFF when not claimed) |
| io_hit_o | output | 1 | Access claimed by the pair |

## Verification
Two cases can fall in the same cycle.

- **Read and write on the data port.** The bench strobes both in one cycle. The returned byte must equal the value held before the write, and a read on the following cycle must return the written byte.
- **Enable drop and a write.** The bench lowers the enable in the same cycle as a write to each port. It then re-enables the window and reads back, confirming that neither the pointer nor the entry moved.

// File: rtl/sioc_pkg.sv
package sioc_pkg;
  localparam int IDX_W = 8;
  localparam int NUM_ENTRIES = 1 << IDX_W;

  function automatic logic sioc_writable(input logic [IDX_W-1:0] idx);
    case (idx)
      8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hE7, 8'hE8,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6,
      8'hF8, 8'hFC: sioc_writable = 1'b1;
      default:      sioc_writable = 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] sioc_reset_val(input logic [IDX_W-1:0] idx);
    case (idx)
      8'hE0:   sioc_reset_val = 8'h3C;
      8'hE2:   sioc_reset_val = 8'h03;
      8'hE3:   sioc_reset_val = 8'hFC;
      8'hE6:   sioc_reset_val = 8'hDE;
      8'hE7:   sioc_reset_val = 8'hFE; // serial port 1 base selector
      8'hE8:   sioc_reset_val = 8'hBE; // serial port 2 base selector
      default: sioc_reset_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sioc_decode.sv
module sioc_decode #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_PORT = 16'h03F0,
  parameter logic [15:0] DATA_PORT  = 16'h03F1
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              rd_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(INDEX_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_PORT);

  logic at_idx, at_dat;

  always_comb begin
    at_idx   = en_i && (addr_i == IDX_A);
    at_dat   = en_i && (addr_i == DAT_A);
    idx_wr_o = at_idx && wr_i;
    dat_wr_o = at_dat && wr_i;
    rd_o     = (at_idx || at_dat) && rd_i;
    hit_o    = (at_idx || at_dat) && (rd_i || wr_i);
  end
endmodule

// File: rtl/sioc_store.sv
module sioc_store
  import sioc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] cur_o
);
  logic [IDX_W-1:0]  ptr_q;
  logic [DATA_W-1:0] ent [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (idx_wr_i) ptr_q <= wdata_i[IDX_W-1:0];
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    if (sioc_writable(IDX)) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        ent[i] <= DATA_W'(sioc_reset_val(IDX));
        else if (dat_wr_i && ptr_q == IDX)  ent[i] <= wdata_i;
      end
    end else begin : g_ro
      // protected entries never leave their reset value
      assign ent[i] = DATA_W'(sioc_reset_val(IDX));
    end
  end

  assign ptr_o = ptr_q;
  assign cur_o = ent[ptr_q];
endmodule

// File: rtl/sioc_cfg_regs.sv
module sioc_cfg_regs
  import sioc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [15:0] INDEX_PORT = 16'h03F0,
  parameter logic [15:0] DATA_PORT  = 16'h03F1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              io_hit_o
);
  logic             idx_wr, dat_wr, rd_sel;
  logic [IDX_W-1:0] ptr_w;
  logic [DATA_W-1:0] cur_w;

  sioc_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .en_i(cfg_en_i), .addr_i(io_addr_i), .wr_i(io_wr_i), .rd_i(io_rd_i),
    .idx_wr_o(idx_wr), .dat_wr_o(dat_wr), .rd_o(rd_sel), .hit_o(io_hit_o)
  );

  sioc_store #(.DATA_W(DATA_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_wr_i(idx_wr), .dat_wr_i(dat_wr),
    .wdata_i(io_wdata_i), .ptr_o(ptr_w), .cur_o(cur_w)
  );

  // unclaimed reads float high, as on an idle bus
  assign io_rdata_o = rd_sel ? cur_w : '1;
endmodule

// File: rtl/sioc_cfg_chk.sv
module sioc_cfg_chk
  import sioc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [15:0] INDEX_PORT = 16'h03F0,
  parameter logic [15:0] DATA_PORT  = 16'h03F1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              hit_i,
  input logic [IDX_W-1:0]  ptr_i,
  input logic [DATA_W-1:0] cur_i
);
  logic wr_idx, wr_dat;
  assign wr_idx = en_i && wr_i && addr_i == ADDR_W'(INDEX_PORT);
  assign wr_dat = en_i && wr_i && addr_i == ADDR_W'(DATA_PORT);

  AST_IDX_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idx |=> ptr_i == $past(wdata_i[IDX_W-1:0])); // R2
  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dat && sioc_writable(ptr_i) |=> cur_i == $past(wdata_i)); // R4
  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dat && !sioc_writable(ptr_i) |=> cur_i == $past(cur_i)); // R5
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_i && rdata_i == '1); // R7
  AST_DIS_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ptr_i == $past(ptr_i)); // R7
  AST_MISS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |-> rdata_i == '1); // R8
endmodule

bind sioc_cfg_regs sioc_cfg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg_en_i), .addr_i(io_addr_i),
  .wr_i(io_wr_i), .wdata_i(io_wdata_i), .rdata_i(io_rdata_o),
  .hit_i(io_hit_o), .ptr_i(ptr_w), .cur_i(cur_w)
);

// File: tb/sim_sioc_cfg_regs.sv
`timescale 1ns/1ps
module sim_sioc_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [15:0] PI = 16'h03F0, PD = 16'h03F1;

  always #2 clk = ~clk;

  sioc_cfg_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .io_addr_i(addr),
    .io_wr_i(wr), .io_rd_i(rd), .io_wdata_i(wdata),
    .io_rdata_o(rdata), .io_hit_o(hit)
  );

  function automatic bit exp_wr(input int i);
    return !((i <= 8'hDF) || i == 8'hE4 || i == 8'hE5 ||
             (i >= 8'hE9 && i <= 8'hED) || i == 8'hF3 || i == 8'hF5 ||
             i == 8'hF7 || (i >= 8'hF9 && i <= 8'hFB) || i >= 8'hFD);
  endfunction

  function automatic logic [7:0] exp_rst(input int i);
    case (i)
      8'hE0: return 8'h3C; 8'hE2: return 8'h03; 8'hE3: return 8'hFC;
      8'hE6: return 8'hDE; 8'hE7: return 8'hFE; 8'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; returns what was seen before the edge
  task automatic bus(input logic [15:0] a, input logic w, input logic r,
                     input logic [7:0] d, output logic [7:0] q, output logic h);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    #1; q = rdata; h = hit;
    @(posedge clk); #0.5;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic wr_b(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] q; logic h;
    bus(a, 1'b1, 1'b0, d, q, h);
  endtask

  task automatic rd_b(input logic [15:0] a, output logic [7:0] q, output logic h);
    bus(a, 1'b0, 1'b1, 8'h00, q, h);
  endtask

  initial begin
    logic [7:0] q; logic h;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: pointer resets to zero, entry 0 reads 0x00
    rd_b(PD, q, h);
    chk("R1 ptr", {h, q}, {1'b1, 8'h00});
    // sweep every index, two patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] pat, prev;
        pat = (pass == 0) ? (8'(i) ^ 8'h5A) : ~(8'(i) + 8'h21);
        prev = (pass == 0) ? exp_rst(i) : (exp_wr(i) ? (8'(i) ^ 8'h5A) : exp_rst(i));
        wr_b(PI, 8'(i));                                   // R2
        rd_b(PD, q, h);
        chk(pass == 0 ? "R1 reset value" : "R3 data read", {h, q}, {1'b1, prev});
        wr_b(PD, pat);
        rd_b((i % 2 == 0) ? PD : PI, q, h);                // R3 both ports
        chk(exp_wr(i) ? "R4 writable" : "R5 protected", {h, q},
            {1'b1, exp_wr(i) ? pat : exp_rst(i)});
      end
    end
    // R6: serial base selectors take non-default values
    wr_b(PI, 8'hE7); wr_b(PD, 8'h11); rd_b(PD, q, h);
    chk("R6 E7", {1'b0, q}, {1'b0, 8'h11});
    wr_b(PI, 8'hE8); wr_b(PD, 8'h00); rd_b(PD, q, h);
    chk("R6 E8", {1'b0, q}, {1'b0, 8'h00});
    // R7: disabled window
    wr_b(PI, 8'hE0); wr_b(PD, 8'hAA);
    @(negedge clk); en = 1'b0;
    rd_b(PD, q, h);
    chk("R7 read disabled", {h, q}, {1'b0, 8'hFF});
    rd_b(PI, q, h);
    chk("R7 index read disabled", {h, q}, {1'b0, 8'hFF});
    wr_b(PD, 8'h55);
    wr_b(PI, 8'hE2);
    @(negedge clk); en = 1'b1;
    rd_b(PD, q, h);
    chk("R7 no state change", {h, q}, {1'b1, 8'hAA});
    // R7: enable falls in the same cycle as a data write
    @(negedge clk);
    addr = PD; wr = 1'b1; wdata = 8'h66; en = 1'b0;
    @(posedge clk); #0.5; wr = 1'b0; en = 1'b1;
    rd_b(PD, q, h);
    chk("R7 write on enable drop", {h, q}, {1'b1, 8'hAA});
    // R8: other addresses
    wr_b(16'h03F2, 8'h77);
    wr_b(16'h13F1, 8'h77);
    bus(16'h02F0, 1'b1, 1'b1, 8'hE3, q, h);
    chk("R8 miss", {h, q}, {1'b0, 8'hFF});
    rd_b(PD, q, h);
    chk("R8 no effect", {h, q}, {1'b1, 8'hAA});
    // R9: read and write together
    bus(PD, 1'b1, 1'b1, 8'h33, q, h);
    chk("R9 old value", {h, q}, {1'b1, 8'hAA});
    rd_b(PD, q, h);
    chk("R9 new value", {h, q}, {1'b1, 8'h33});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule